// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block collects the interrupt conditions of a UART and turns them into a single interrupt request line and a prioritized 4-bit identification code of the kind a 16550-style controller reports. Five conditions are encoded: receive line errors, receive data available, receive character timeout, transmit slot available and modem status. Each group is gated by its own enable bit. A sixth condition, receive line idle, is not encoded in the code. It is kept as a separate sticky flag that software clears by writing a one to it.

The block keeps whatever state the clearing rules need: sticky line-error and timeout flags, a delta-CTS flag, a transmit-slot pending bit and the idle flag. It updates that state from read and write strobes that the register decoder supplies. The receive data path and the baud generation sit outside the block.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the code `iir_id_o` is 0x1 (nothing pending), `pending_o` is 0, `irq_o` is 0 and `idle_flag_o` is 0.
- R2: Any bit of `ls_evt_i` latches a line-error flag one clock later, reported as code 0x6 when `ier_i[2]` is set. `lsr_rd_i` clears the flag, but an error event in the same cycle as the read keeps it set.
- R3: While `rx_avail_i` is high and `ier_i[0]` is set, the code is 0x4, unless a higher source is pending.
- R4: A pulse on `rx_to_i` latches a timeout flag, reported as 0xC (enable `ier_i[0]`, ahead of 0x4). It is cleared by `rbr_rd_i`.
- R5: A rising edge of (`thr_empty_i` and `ier_i[1]`) makes the transmit slot pending, reported as 0x2. It is cleared by `thr_wr_i`, by `iir_rd_i` while the code reads 0x2, or by the condition going low. An `iir_rd_i` while another code is shown leaves it pending.
- R6: A change of `cts_i` from its previous sampled value latches a delta flag, reported as 0x0 when `ier_i[3]` is set. It is cleared by `msr_rd_i`.
- R7: Priority from highest to lowest: line error 0x6, timeout 0xC, data available 0x4, transmit slot 0x2, modem 0x0.
- R8: A disabled source is not reported and does not raise `irq_o`, but its latched flag is kept. Setting the enable again reports it.
- R9: A pulse on `rx_idle_i` sets `idle_flag_o` and leaves the code unchanged. `iir_wr_i` with `iir_wdata_i`=1 clears the flag, and with `iir_wdata_i`=0 it has no effect.
- R10: `pending_o` is the inverse of code bit 0. `irq_o` is `pending_o` OR (`idle_flag_o` AND `ier_i[4]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 5 | Enables: [0] rx data/timeout, [1] tx slot, [2] line error, [3] modem, [4] idle |
| ls_evt_i | input | LS_W | Line error event pulses (overrun, parity, framing, break, FIFO error) |
| lsr_rd_i | input | 1 | Line status register read strobe |
| rx_avail_i | input | 1 | Receive FIFO at or above trigger level |
| rx_to_i | input | 1 | Character timeout event pulse |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_empty_i | input | 1 | Transmit holding slot available |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| cts_i | input | 1 | Synchronized clear-to-send level |
| msr_rd_i | input | 1 | Modem status register read strobe |
| rx_idle_i | input | 1 | Receive line idle detected pulse |
| iir_rd_i | input | 1 | Identification register read strobe |
| iir_wr_i | input | 1 | Identification register write strobe |
| iir_wdata_i | input | 1 | Write data at the idle flag bit |
| iir_id_o | output | 4 | Prioritized identification code |
| pending_o | output | 1 | An enabled encoded source is pending |
| idle_flag_o | output | 1 | Receive line idle flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the corners where the clearing rules interact. The first is a line-status read in the same cycle as a new error event. A design that lets the clear win there loses the error. The second is an identification read while a higher source hides a pending transmit slot. A design that acknowledges it blindly drops the transmit interrupt, and this shows up once the higher source goes away. It also masks a latched error and then enables it again, to catch a design that gates the flag instead of the report. Finally it writes a zero to the idle flag, to catch a design that clears on any write.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_MODEM  = 4'h0,
    IID_NONE   = 4'h1,
    IID_TX     = 4'h2,
    IID_RXDATA = 4'h4,
    IID_LINE   = 4'h6,
    IID_RXTO   = 4'hC
  } iid_e;

  localparam int IE_RX   = 0;
  localparam int IE_TX   = 1;
  localparam int IE_LS   = 2;
  localparam int IE_MS   = 3;
  localparam int IE_IDLE = 4;
  localparam int IE_W    = 5;
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  // set has precedence so an event coincident with a clear is not lost
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[g] <= 1'b0;
      else if (set_i[g])  flag_o[g] <= 1'b1;
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_tx_slot.sv
module uart_irq_tx_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic empty_i,
  input  logic en_i,
  input  logic wr_i,
  input  logic ack_i,
  output logic pend_o
);
  logic arm, arm_q;
  assign arm = empty_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      arm_q <= arm;
      if (wr_i || !arm)  pend_o <= 1'b0;
      else if (!arm_q)   pend_o <= 1'b1;
      else if (ack_i)    pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [IE_W-1:0] ier_i,
  input  logic            ls_i,
  input  logic            to_i,
  input  logic            rxa_i,
  input  logic            tx_i,
  input  logic            ms_i,
  output iid_e            id_o
);
  always_comb begin
    if      (ls_i  && ier_i[IE_LS]) id_o = IID_LINE;
    else if (to_i  && ier_i[IE_RX]) id_o = IID_RXTO;
    else if (rxa_i && ier_i[IE_RX]) id_o = IID_RXDATA;
    else if (tx_i)                  id_o = IID_TX;
    else if (ms_i  && ier_i[IE_MS]) id_o = IID_MODEM;
    else                            id_o = IID_NONE;
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int LS_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IE_W-1:0] ier_i,
  input  logic [LS_W-1:0] ls_evt_i,
  input  logic            lsr_rd_i,
  input  logic            rx_avail_i,
  input  logic            rx_to_i,
  input  logic            rbr_rd_i,
  input  logic            thr_empty_i,
  input  logic            thr_wr_i,
  input  logic            cts_i,
  input  logic            msr_rd_i,
  input  logic            rx_idle_i,
  input  logic            iir_rd_i,
  input  logic            iir_wr_i,
  input  logic            iir_wdata_i,
  output logic [3:0]      iir_id_o,
  output logic            pending_o,
  output logic            idle_flag_o,
  output logic            irq_o
);
  localparam int NF = LS_W + 3;  // line errors, timeout, delta cts, idle
  localparam int F_TO = LS_W;
  localparam int F_MS = LS_W + 1;
  localparam int F_ID = LS_W + 2;

  logic          cts_q;
  logic [NF-1:0] f_set, f_clr, flags;
  logic          ls_pend, to_pend, ms_pend, tx_pend, tx_ack;
  iid_e          id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cts_q <= 1'b0;
    else         cts_q <= cts_i;
  end

  assign f_set = {rx_idle_i, cts_i ^ cts_q, rx_to_i, ls_evt_i};
  assign f_clr = {iir_wr_i & iir_wdata_i, msr_rd_i, rbr_rd_i, {LS_W{lsr_rd_i}}};

  uart_irq_sticky #(.W(NF)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (f_set),
    .clr_i  (f_clr),
    .flag_o (flags)
  );

  assign ls_pend     = |flags[LS_W-1:0];
  assign to_pend     = flags[F_TO];
  assign ms_pend     = flags[F_MS];
  assign idle_flag_o = flags[F_ID];

  assign tx_ack = iir_rd_i && (id == IID_TX);

  uart_irq_tx_slot u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .empty_i (thr_empty_i),
    .en_i    (ier_i[IE_TX]),
    .wr_i    (thr_wr_i),
    .ack_i   (tx_ack),
    .pend_o  (tx_pend)
  );

  uart_irq_prio u_prio (
    .ier_i (ier_i),
    .ls_i  (ls_pend),
    .to_i  (to_pend),
    .rxa_i (rx_avail_i),
    .tx_i  (tx_pend),
    .ms_i  (ms_pend),
    .id_o  (id)
  );

  assign iir_id_o  = id;
  assign pending_o = ~id[0];
  assign irq_o     = pending_o | (idle_flag_o & ier_i[IE_IDLE]);
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk
  import uart_irq_pkg::*;
#(
  parameter int LS_W = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [IE_W-1:0] ier_i,
  input logic [LS_W-1:0] ls_evt_i,
  input logic            rx_to_i,
  input logic            thr_wr_i,
  input logic            rx_idle_i,
  input logic            iir_rd_i,
  input logic            tx_pend,
  input logic            ls_pend,
  input logic [3:0]      iir_id_o,
  input logic            pending_o,
  input logic            idle_flag_o
);
  a_r2_ls_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ls_evt_i) |=> ls_pend);
  a_r4_to_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_to_i && ier_i[IE_RX] && !(|ls_evt_i) && !ls_pend) |=>
      (iir_id_o == IID_RXTO) || !ier_i[IE_RX] || ls_pend);
  a_r5_wr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !tx_pend);
  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && iir_id_o == IID_TX) |=> !tx_pend);
  a_r7_line_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_pend && ier_i[IE_LS]) |-> (iir_id_o == IID_LINE));
  a_r9_idle_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_idle_i |=> idle_flag_o);
  a_r10_none_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_o |-> (iir_id_o == IID_NONE));
endmodule

bind uart_irq_id uart_irq_id_chk #(.LS_W(LS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ier_i       (ier_i),
  .ls_evt_i    (ls_evt_i),
  .rx_to_i     (rx_to_i),
  .thr_wr_i    (thr_wr_i),
  .rx_idle_i   (rx_idle_i),
  .iir_rd_i    (iir_rd_i),
  .tx_pend     (tx_pend),
  .ls_pend     (ls_pend),
  .iir_id_o    (iir_id_o),
  .pending_o   (pending_o),
  .idle_flag_o (idle_flag_o)
);

// File: tb/uart_irq_id_test.sv
module uart_irq_id_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ier = '0;
  logic [4:0] ls_evt = '0;
  logic lsr_rd = 0, rx_avail = 0, rx_to = 0, rbr_rd = 0, thr_empty = 0, thr_wr = 0;
  logic cts = 0, msr_rd = 0, rx_idle = 0, iir_rd = 0, iir_wr = 0, iir_wdata = 0;
  logic [3:0] id;
  logic pend, idle, irq;

  typedef struct {
    string      tag;
    logic [3:0] id;
    logic       irq;
    logic       idle;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_id uut (
    .clk_i(clk), .rst_ni(rst_n), .ier_i(ier), .ls_evt_i(ls_evt), .lsr_rd_i(lsr_rd),
    .rx_avail_i(rx_avail), .rx_to_i(rx_to), .rbr_rd_i(rbr_rd), .thr_empty_i(thr_empty),
    .thr_wr_i(thr_wr), .cts_i(cts), .msr_rd_i(msr_rd), .rx_idle_i(rx_idle),
    .iir_rd_i(iir_rd), .iir_wr_i(iir_wr), .iir_wdata_i(iir_wdata),
    .iir_id_o(id), .pending_o(pend), .idle_flag_o(idle), .irq_o(irq)
  );

  // driver: inputs are set at a negedge, expectation holds after the next posedge
  task automatic step(string tag, logic [3:0] e_id, logic e_irq, logic e_idle);
    exp_t e;
    e.tag = tag; e.id = e_id; e.irq = e_irq; e.idle = e_idle;
    q.push_back(e);
    @(negedge clk);
    ls_evt = '0; lsr_rd = 0; rx_to = 0; rbr_rd = 0; thr_wr = 0;
    msr_rd = 0; rx_idle = 0; iir_rd = 0; iir_wr = 0; iir_wdata = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (id !== e.id || irq !== e.irq || idle !== e.idle || pend !== ~e.id[0]) begin
        fails++;
        $display("FAIL %s: id=%h irq=%b idle=%b pend=%b expected id=%h irq=%b idle=%b pend=%b",
                 e.tag, id, irq, idle, pend, e.id, e.irq, e.idle, ~e.id[0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: expired expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1 reset", 4'h1, 0, 0);
    ier = 5'h1F; rx_avail = 1;            step("R3 data avail", 4'h4, 1, 0);
    rx_to = 1;                            step("R4 timeout", 4'hC, 1, 0);
                                          step("R4 timeout held", 4'hC, 1, 0);
    ls_evt = 5'b00100;                    step("R2 R7 line err", 4'h6, 1, 0);
    lsr_rd = 1; ls_evt = 5'b00001;        step("R2 read+event", 4'h6, 1, 0);
    lsr_rd = 1;                           step("R2 read clears", 4'hC, 1, 0);
    rbr_rd = 1; rx_avail = 0;             step("R4 rbr clears", 4'h1, 0, 0);
    thr_empty = 1;                        step("R5 tx slot", 4'h2, 1, 0);
    iir_rd = 1;                           step("R5 iir ack", 4'h1, 0, 0);
    thr_empty = 0;                        step("R5 empty low", 4'h1, 0, 0);
    thr_empty = 1;                        step("R5 tx again", 4'h2, 1, 0);
    thr_wr = 1;                           step("R5 thr write", 4'h1, 0, 0);
    ier = 5'h1B; ls_evt = 5'b10000;       step("R8 masked", 4'h1, 0, 0);
    ier = 5'h1F;                          step("R8 reenabled", 4'h6, 1, 0);
    lsr_rd = 1;                           step("R2 cleared", 4'h1, 0, 0);
    thr_empty = 0;                        step("R5 prep", 4'h1, 0, 0);
    thr_empty = 1;                        step("R5 pend", 4'h2, 1, 0);
    rx_avail = 1;                         step("R7 rx over tx", 4'h4, 1, 0);
    iir_rd = 1;                           step("R5 hidden read", 4'h4, 1, 0);
    rx_avail = 0;                         step("R5 still pend", 4'h2, 1, 0);
    iir_rd = 1;                           step("R5 ack", 4'h1, 0, 0);
    cts = 1;                              step("R6 dcts", 4'h0, 1, 0);
    msr_rd = 1;                           step("R6 msr clears", 4'h1, 0, 0);
    cts = 0;                              step("R6 dcts fall", 4'h0, 1, 0);
    ier = 5'h17;                          step("R8 modem masked", 4'h1, 0, 0);
    ier = 5'h1F; msr_rd = 1;              step("R6 cleared", 4'h1, 0, 0);
    thr_empty = 0;                        step("R7 prep", 4'h1, 0, 0);
    thr_empty = 1; cts = 1;               step("R7 tx over modem", 4'h2, 1, 0);
    iir_rd = 1;                           step("R7 modem next", 4'h0, 1, 0);
    msr_rd = 1;                           step("R6 done", 4'h1, 0, 0);
    rx_idle = 1;                          step("R9 R10 idle", 4'h1, 1, 1);
    ier = 5'h0F;                          step("R10 idle masked", 4'h1, 0, 1);
    iir_wr = 1; iir_wdata = 0;            step("R9 write zero", 4'h1, 0, 1);
    iir_wr = 1; iir_wdata = 1;            step("R9 w1c", 4'h1, 0, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule